// File: doc/BRIEF.md
# Boost-Network Switch Gate Scheduler

This block drives the two active switches of the boost impedance network that feeds a three-level inverter. It keeps its own triangular carrier, which runs a quarter period behind the inverter carrier. Each carrier period is split into five intervals, placed in a fixed order starting at the carrier valley. The first is shoot-through, with both switches on. Next comes the interval with only the first switch on. Then comes a boost interval with both switches on while the inverter is not in shoot-through. After that comes the interval with only the second switch on. The period ends with both switches off.

Interval lengths come from three unsigned fractions: the shoot-through fraction `st_frac_i`, the extended duty fraction `ext_frac_i` and the balance ratio `bal_frac_i`. Each has `FRAC_W` fraction bits, and one full unit equals 2^FRAC_W. The sign of the signed capacitor voltage difference `cdiff_i` moves time from one single-switch interval to the other. The total single-switch time does not change, so the boost factor is kept. The lengths are recomputed once per period, in whole clock ticks. A sync strobe aligns the carrier with the inverter. A sticky flag records any cycle in which the inverter requests shoot-through while the two gates are not both on.

Top module: `boostnet_gate_pwm`

## Requirements
- R1: Reset clears the carrier phase to 0 and the error flag. It puts the interval state at 4 (off) with both gates low. Because no lengths are latched yet, the whole first period after reset stays off.
- R2: The shoot-through interval (state 0, both gates high) starts at phase 0. It lasts nst = floor(s·PERIOD/2^FRAC_W) ticks, where s is `st_frac_i` limited to at most half a unit.
- R3: The boost interval (state 2, both gates high) comes directly after the first single-switch interval. It lasts exactly nst ticks.
- R4: The extended duty fraction is limited to the range [s, 1 − s]. The two single-switch intervals together take 2·h ticks, where h = floor((floor(e·PERIOD/2^FRAC_W) − nst)/2) and e is the limited fraction. When `cdiff_i` is zero, each takes h ticks.
- R5: When `cdiff_i` is positive, the first-switch-only interval (state 1, only `gate_a_o` high) takes h + d ticks and the second-switch-only interval takes h − d ticks. Here d = floor(a·h/2^FRAC_W), and a is `bal_frac_i` limited to at most one unit.
- R6: When `cdiff_i` is negative, the first-switch-only interval takes h − d ticks. The second-switch-only interval (state 3, only `gate_b_o` high) takes h + d ticks.
- R7: All ticks left after the four intervals, including every rounding remainder, belong to the off interval (state 4, both gates low). It runs until the end of the period.
- R8: Input values are captured only on the clock edge where the phase wraps from PERIOD−1 to 0. A change that is reverted before that edge has no effect on any period.
- R9: A sync pulse sets the phase to 3·PERIOD/4 on the next edge. The next period therefore starts PERIOD/4 clocks later, and the intervals latched earlier are kept until then.
- R10: If `st_req_i` is high in a cycle where the two gates are not both high, `st_err_o` is high from the next cycle on. It stays high until reset.
- R11: `gate_a_o` is high exactly in states 0, 1 and 2. `gate_b_o` is high exactly in states 0, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of the carrier |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Carrier alignment strobe from the inverter stage |
| st_req_i | input | 1 | Inverter shoot-through flag |
| st_frac_i | input | FRAC_W | Shoot-through fraction of the period |
| ext_frac_i | input | FRAC_W | Extended duty fraction |
| bal_frac_i | input | FRAC_W+1 | Balance offset ratio |
| cdiff_i | input | VD_W | Signed upper-minus-lower capacitor voltage difference |
| gate_a_o | output | 1 | Gate of the first network switch |
| gate_b_o | output | 1 | Gate of the second network switch |
| ivl_o | output | 3 | Current interval: 0 shoot-through, 1 first only, 2 boost, 3 second only, 4 off |
| st_err_o | output | 1 | Sticky shoot-through mismatch flag |

## Verification
The state and gate outputs are registered and change on the same edge as the phase. The inputs present at the edge where the phase leaves PERIOD−1 therefore shape the whole period that begins on that edge. The bench applies new inputs just after the phase-0 sample and checks every tick of a period against bounds it computed for the inputs of the previous period. The error flag is due one edge after the offending `st_req_i`, and the phase jump one edge after `sync_i`. Samples are taken on falling edges, so each observation is of the value registered on the rising edge just before.

// File: rtl/bn_pkg.sv
package bn_pkg;

    // Interval codes, in the order they occur after the carrier valley
    typedef enum logic [2:0] {
        IV_ST    = 3'd0,
        IV_A     = 3'd1,
        IV_BOOST = 3'd2,
        IV_B     = 3'd3,
        IV_OFF   = 3'd4
    } ivl_e;

endpackage

// File: rtl/bn_interval_calc.sv
module bn_interval_calc #(
    parameter int PERIOD = 200,
    parameter int FRAC_W = 8,
    parameter int PH_W   = 8,
    parameter int VD_W   = 12
) (
    input  logic [FRAC_W-1:0]      st_frac_i,
    input  logic [FRAC_W-1:0]      ext_frac_i,
    input  logic [FRAC_W:0]        bal_frac_i,
    input  logic signed [VD_W-1:0] cdiff_i,
    output logic [PH_W:0]          b_st_o,
    output logic [PH_W:0]          b_a_o,
    output logic [PH_W:0]          b_boost_o,
    output logic [PH_W:0]          b_b_o
);
    localparam int FW1 = FRAC_W + 1;
    localparam int PW  = FRAC_W + PH_W + 2;
    localparam logic [FW1-1:0] ONE      = FW1'(1) << FRAC_W;
    localparam logic [FW1-1:0] HALF_ONE = ONE >> 1;
    localparam logic [PW-1:0]  T_EXT    = PW'(PERIOD);

    logic [FW1-1:0] st_c, ext_w, ext_c, ext_hi, bal_c;
    logic [PW-1:0]  n_st, n_ext, n_single, n_half, n_delta, n_a, n_b;
    logic [PW-1:0]  e_a, e_boost, e_b;

    always_comb begin
        // clamp the fractions to their legal ranges
        st_c   = ({1'b0, st_frac_i} > HALF_ONE) ? HALF_ONE : {1'b0, st_frac_i};
        ext_hi = ONE - st_c;
        ext_w  = {1'b0, ext_frac_i};
        if (ext_w < st_c) begin
            ext_c = st_c;
        end else if (ext_w > ext_hi) begin
            ext_c = ext_hi;
        end else begin
            ext_c = ext_w;
        end
        bal_c = (bal_frac_i > ONE) ? ONE : bal_frac_i;

        // tick counts, truncated; leftovers fall to the off interval
        n_st     = (PW'(st_c) * T_EXT) >> FRAC_W;
        n_ext    = (PW'(ext_c) * T_EXT) >> FRAC_W;
        n_single = n_ext - n_st;
        n_half   = n_single >> 1;
        n_delta  = (PW'(bal_c) * n_half) >> FRAC_W;

        if (cdiff_i > 0) begin
            n_a = n_half + n_delta;
            n_b = n_half - n_delta;
        end else if (cdiff_i < 0) begin
            n_a = n_half - n_delta;
            n_b = n_half + n_delta;
        end else begin
            n_a = n_half;
            n_b = n_half;
        end

        e_a     = n_st + n_a;
        e_boost = e_a + n_st;
        e_b     = e_boost + n_b;

        b_st_o    = (PH_W+1)'(n_st);
        b_a_o     = (PH_W+1)'(e_a);
        b_boost_o = (PH_W+1)'(e_boost);
        b_b_o     = (PH_W+1)'(e_b);
    end

endmodule

// File: rtl/bn_carrier.sv
module bn_carrier #(
    parameter int PERIOD = 200,
    parameter int PH_W   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_i,
    output logic [PH_W-1:0] ph_o,
    output logic [PH_W-1:0] ph_next_o,
    output logic            valley_o
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PERIOD - 1);
    // a quarter period before the valley of this carrier
    localparam logic [PH_W-1:0] SYNC_PH = PH_W'(PERIOD - PERIOD / 4);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } car_t;

    car_t car_q, car_d;

    always_comb begin
        car_d    = car_q;
        valley_o = 1'b0;
        if (sync_i) begin
            car_d.ph = SYNC_PH;
        end else if (car_q.ph == LAST_PH) begin
            car_d.ph = '0;
            valley_o = 1'b1;
        end else begin
            car_d.ph = car_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car_q <= '0;
        end else begin
            car_q <= car_d;
        end
    end

    assign ph_o      = car_q.ph;
    assign ph_next_o = car_d.ph;

endmodule

// File: rtl/boostnet_gate_pwm.sv
module boostnet_gate_pwm
    import bn_pkg::*;
#(
    parameter int PERIOD = 200,
    parameter int FRAC_W = 8,
    parameter int VD_W   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sync_i,
    input  logic                   st_req_i,
    input  logic [FRAC_W-1:0]      st_frac_i,
    input  logic [FRAC_W-1:0]      ext_frac_i,
    input  logic [FRAC_W:0]        bal_frac_i,
    input  logic signed [VD_W-1:0] cdiff_i,
    output logic                   gate_a_o,
    output logic                   gate_b_o,
    output logic [2:0]             ivl_o,
    output logic                   st_err_o
);
    localparam int PH_W = $clog2(PERIOD);

    typedef struct packed {
        logic [PH_W:0] b_st;
        logic [PH_W:0] b_a;
        logic [PH_W:0] b_boost;
        logic [PH_W:0] b_b;
        ivl_e          ivl;
        logic          err;
    } ctl_t;

    localparam ctl_t CTL_RST = '{b_st: '0, b_a: '0, b_boost: '0, b_b: '0,
                                 ivl: IV_OFF, err: 1'b0};

    ctl_t ctl_q, ctl_d;

    logic [PH_W-1:0] ph_w, ph_next_w;
    logic            valley_w;
    logic [PH_W:0]   b_st_w, b_a_w, b_boost_w, b_b_w;

    bn_carrier #(.PERIOD(PERIOD), .PH_W(PH_W)) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (sync_i),
        .ph_o     (ph_w),
        .ph_next_o(ph_next_w),
        .valley_o (valley_w)
    );

    bn_interval_calc #(.PERIOD(PERIOD), .FRAC_W(FRAC_W), .PH_W(PH_W), .VD_W(VD_W)) u_calc (
        .st_frac_i (st_frac_i),
        .ext_frac_i(ext_frac_i),
        .bal_frac_i(bal_frac_i),
        .cdiff_i   (cdiff_i),
        .b_st_o    (b_st_w),
        .b_a_o     (b_a_w),
        .b_boost_o (b_boost_w),
        .b_b_o     (b_b_w)
    );

    // map a phase onto the interval whose end bound it has not reached
    function automatic ivl_e decode(input logic [PH_W-1:0] p, input ctl_t c);
        logic [PH_W:0] pe;
        pe = {1'b0, p};
        if (pe < c.b_st)         return IV_ST;
        else if (pe < c.b_a)     return IV_A;
        else if (pe < c.b_boost) return IV_BOOST;
        else if (pe < c.b_b)     return IV_B;
        else                     return IV_OFF;
    endfunction

    always_comb begin
        ctl_d = ctl_q;
        if (valley_w) begin
            ctl_d.b_st    = b_st_w;
            ctl_d.b_a     = b_a_w;
            ctl_d.b_boost = b_boost_w;
            ctl_d.b_b     = b_b_w;
        end
        ctl_d.ivl = decode(ph_next_w, ctl_d);
        ctl_d.err = ctl_q.err | (st_req_i & ~(gate_a_o & gate_b_o));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign gate_a_o = ctl_q.ivl inside {IV_ST, IV_A, IV_BOOST};
    assign gate_b_o = ctl_q.ivl inside {IV_ST, IV_BOOST, IV_B};
    assign ivl_o    = ctl_q.ivl;
    assign st_err_o = ctl_q.err;

endmodule

// File: rtl/boostnet_gate_pwm_chk.sv
module boostnet_gate_pwm_chk #(
    parameter int PERIOD = 200,
    parameter int PH_W   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sync_i,
    input logic            st_req_i,
    input logic            gate_a_o,
    input logic            gate_b_o,
    input logic [2:0]      ivl_o,
    input logic            st_err_o,
    input logic [PH_W-1:0] ph_i
);
    localparam logic [PH_W-1:0] SYNC_PH = PH_W'(PERIOD - PERIOD / 4);

    AST_ST_BOTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_o == 3'd0) |-> (gate_a_o && gate_b_o)); // R2
    AST_BOOST_BOTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_o == 3'd2) |-> (gate_a_o && gate_b_o)); // R3
    AST_A_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_o == 3'd1) |-> (gate_a_o && !gate_b_o)); // R5
    AST_B_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_o == 3'd3) |-> (!gate_a_o && gate_b_o)); // R6
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_o == 3'd4) |-> (!gate_a_o && !gate_b_o)); // R7
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_o <= 3'd4); // R11
    AST_SYNC_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (ph_i == SYNC_PH)); // R9
    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req_i && !(gate_a_o && gate_b_o)) |=> st_err_o); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_err_o |=> st_err_o); // R10

endmodule

bind boostnet_gate_pwm boostnet_gate_pwm_chk #(.PERIOD(PERIOD), .PH_W(PH_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (sync_i),
    .st_req_i(st_req_i),
    .gate_a_o(gate_a_o),
    .gate_b_o(gate_b_o),
    .ivl_o   (ivl_o),
    .st_err_o(st_err_o),
    .ph_i    (ph_w)
);

// File: tb/boostnet_gate_pwm_test.sv
module boostnet_gate_pwm_test;
    localparam int CLK_PERIOD = 10;
    localparam int T      = 200;
    localparam int FRAC_W = 8;
    localparam int VD_W   = 12;
    localparam int ONE    = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_i = 1'b0;
    logic st_req_i = 1'b0;
    logic [FRAC_W-1:0] st_frac_i = '0;
    logic [FRAC_W-1:0] ext_frac_i = '0;
    logic [FRAC_W:0]   bal_frac_i = '0;
    logic signed [VD_W-1:0] cdiff_i = '0;
    logic gate_a_o, gate_b_o, st_err_o;
    logic [2:0] ivl_o;

    int checks = 0;
    int fails = 0;
    int cb0 = 0, cb1 = 0, cb2 = 0, cb3 = 0;   // bounds of the running period
    int pb0 = 0, pb1 = 0, pb2 = 0, pb3 = 0;   // bounds from the applied inputs
    int prev_vd = 0;

    boostnet_gate_pwm #(.PERIOD(T), .FRAC_W(FRAC_W), .VD_W(VD_W)) uut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .st_req_i(st_req_i),
        .st_frac_i(st_frac_i), .ext_frac_i(ext_frac_i), .bal_frac_i(bal_frac_i),
        .cdiff_i(cdiff_i), .gate_a_o(gate_a_o), .gate_b_o(gate_b_o),
        .ivl_o(ivl_o), .st_err_o(st_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic void calc(input int st, input int ex, input int al, input int vd,
                                 output int b0, output int b1, output int b2, output int b3);
        int sc, hi, ec, ac, nst, nex, half, dl, na, nb;
        sc = (st > ONE/2) ? ONE/2 : st;
        hi = ONE - sc;
        ec = (ex < sc) ? sc : ((ex > hi) ? hi : ex);
        ac = (al > ONE) ? ONE : al;
        nst = (sc * T) / ONE;
        nex = (ec * T) / ONE;
        half = (nex - nst) / 2;
        dl = (ac * half) / ONE;
        if (vd > 0) begin na = half + dl; nb = half - dl; end
        else if (vd < 0) begin na = half - dl; nb = half + dl; end
        else begin na = half; nb = half; end
        b0 = nst; b1 = nst + na; b2 = b1 + nst; b3 = b2 + nb;
    endfunction

    function automatic int exp_ivl(input int p, input int b0, input int b1, input int b2, input int b3);
        if (p < b0) return 0;
        if (p < b1) return 1;
        if (p < b2) return 2;
        if (p < b3) return 3;
        return 4;
    endfunction

    // packs state and gates: 100*a + 10*b + state
    function automatic int pack_exp(input int e);
        int ga, gb;
        ga = (e <= 2) ? 1 : 0;
        gb = (e == 0 || e == 2 || e == 3) ? 1 : 0;
        return 100 * ga + 10 * gb + e;
    endfunction

    function automatic int pack_act();
        return 100 * int'(gate_a_o) + 10 * int'(gate_b_o) + int'(ivl_o);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input int st, input int ex, input int al, input int vd);
        st_frac_i  = FRAC_W'(st);
        ext_frac_i = FRAC_W'(ex);
        bal_frac_i = (FRAC_W+1)'(al);
        cdiff_i    = VD_W'(vd);
        calc(st, ex, al, vd, pb0, pb1, pb2, pb3);
    endtask

    // Checks one whole period against cb*, applying the next inputs at tick 0.
    task automatic run_period(input string req, input int st, input int ex, input int al,
                              input int vd, input bit glitch);
        int mism, ft, fa, fe, e, a;
        mism = 0; ft = 0; fa = 0; fe = 0;
        for (int i = 0; i < T; i++) begin
            @(negedge clk);
            e = exp_ivl(i, cb0, cb1, cb2, cb3);
            a = pack_act();
            if (a != pack_exp(e)) begin
                if (mism == 0) begin ft = i; fa = a; fe = pack_exp(e); end
                mism++;
            end
            st_req_i = (e == 0);
            if (i == 0) apply(st, ex, al, vd);
            if (glitch && i == T/2) begin
                st_frac_i = 8'hFF; ext_frac_i = 8'h00; bal_frac_i = 9'h1FF;
                cdiff_i = -cdiff_i;
            end
            if (glitch && i == T-3) apply(st, ex, al, vd);
        end
        checks++;
        if (mism != 0) begin
            fails++;
            $display("FAIL %s period tick=%0d actual=%0d expected=%0d (ab+state)", req, ft, fa, fe);
        end
        cb0 = pb0; cb1 = pb1; cb2 = pb2; cb3 = pb3;
    endtask

    task automatic finish_up();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        finish_up();
    end

    initial begin
        int e, vd, sel;
        void'($urandom(32'd9137));

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "state in reset", int'(ivl_o), 4);
        check("R1", "gates in reset", int'(gate_a_o) + int'(gate_b_o), 0);
        check("R1", "err in reset", int'(st_err_o), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        run_period("R1", 38, 218, 77, 5, 1'b0);
        run_period("R5 R3", 38, 218, 77, -5, 1'b0);
        run_period("R6", 38, 218, 77, 0, 1'b1);
        run_period("R8 R4", 38, 218, 77, 0, 1'b0);
        run_period("R4", 200, 100, 77, 3, 1'b0);
        run_period("R2 R3", 50, 10, 511, 9, 1'b0);
        run_period("R4", 20, 240, 511, -100, 1'b0);
        run_period("R6", 0, 0, 0, 0, 1'b0);
        run_period("R7", 38, 218, 77, 5, 1'b0);
        prev_vd = 5;

        for (int k = 0; k < 40; k++) begin
            string tag;
            sel = int'($urandom_range(0, 2));
            vd = (sel == 0) ? 0 : ((sel == 1) ? int'($urandom_range(1, 2000))
                                               : -int'($urandom_range(1, 2000)));
            tag = (prev_vd > 0) ? "R5 R11" : ((prev_vd < 0) ? "R6 R11" : "R4 R11");
            run_period(tag, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                       int'($urandom_range(0, 511)), vd, 1'b0);
            prev_vd = vd;
        end
        run_period("R7 R11", 38, 218, 77, 5, 1'b0);
        run_period("R5", 38, 218, 77, 5, 1'b0);

        // R9: sync moves the phase to 3T/4
        @(negedge clk);
        e = exp_ivl(0, cb0, cb1, cb2, cb3);
        check("R9", "state at valley before sync", int'(ivl_o), e);
        st_req_i = (e == 0);
        sync_i = 1'b1;
        @(negedge clk);
        sync_i = 1'b0;
        e = exp_ivl(3*T/4, cb0, cb1, cb2, cb3);
        check("R9", "state after sync", int'(ivl_o), e);
        st_req_i = (e == 0);
        for (int j = 1; j < T/4; j++) begin
            @(negedge clk);
            st_req_i = (exp_ivl(3*T/4 + j, cb0, cb1, cb2, cb3) == 0);
        end
        cb0 = pb0; cb1 = pb1; cb2 = pb2; cb3 = pb3;
        @(negedge clk);
        check("R9", "valley T/4 after sync", pack_act(), pack_exp(0));
        st_req_i = 1'b1;
        for (int j = 1; j < T; j++) begin
            @(negedge clk);
            st_req_i = (exp_ivl(j, cb0, cb1, cb2, cb3) == 0);
        end

        check("R10", "err low with matched requests", int'(st_err_o), 0);

        // R10: request during a first-switch-only tick
        for (int j = 0; j < 30; j++) begin
            @(negedge clk);
            st_req_i = (j == 29) ? 1'b1 : (exp_ivl(j, cb0, cb1, cb2, cb3) == 0);
        end
        @(negedge clk);
        st_req_i = 1'b0;
        check("R10", "err set after mismatch", int'(st_err_o), 1);
        repeat (20) @(negedge clk);
        check("R10", "err sticky", int'(st_err_o), 1);

        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "err cleared by reset", int'(st_err_o), 0);
        check("R1", "state after reset", int'(ivl_o), 4);

        finish_up();
    end

endmodule